// File: doc/BRIEF.md
# Expiry-Guarded LRU Victim Selector

This block picks the way to replace in one set of a set-associative home cache slice whose lines carry lease timestamps. Each way's timestamp records the latest time up to which some remote read copy of that line may still be used. Evicting such a line early would lose the only record of that lease, so the selector follows least-recently-used order but skips every valid way whose timestamp is still ahead of the global timer.

On an allocation request the block answers in the same cycle. It either grants a way or raises a stall when every way is valid and still leased. The stall is recomputed from the timer each cycle, so the requester only has to hold its request. Recency is kept in a pairwise age matrix. A hit marks a way as most recent through a touch input, and every granted allocation marks the filled way as most recent. A freshly filled line is expected to carry timestamp zero, which the guard always treats as expired.

Top module: `lru_victim_sel`

## Requirements
- R1: A valid way whose timestamp is strictly greater than the timer value is never granted.
- R2: When the request is high and every way is valid with a timestamp greater than the timer, `stall_o` is 1 and `grant_o` is 0.
- R3: A valid way is evictable when its timestamp is less than or equal to the timer. Timestamp zero is therefore always evictable. The comparison is unsigned.
- R4: If any way is invalid (`way_valid_i[i]` = 0), the request is granted and `victim_way_o` is the lowest-numbered invalid way, whatever the timestamps are.
- R5: If all ways are valid, the granted way is the least recently used among the evictable ways.
- R6: Grant and stall are combinational in the request, valid bits, timestamps and timer. The stall drops in the same cycle that the timer reaches the smallest outstanding timestamp.
- R7: A clock edge with `touch_en_i` = 1 makes `touch_way_i` the most recent way. The relative order of the other ways is kept.
- R8: A clock edge with `grant_o` = 1 makes the granted way the most recent way. If a touch happens on the same edge, the touch is applied first and the filled way ends up most recent.
- R9: After reset, recency runs from way 0 (least recent) upward to the highest way (most recent).
- R10: With `alloc_req_i` = 0, both `grant_o` and `stall_o` are 0 and recency changes only through touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req_i | input | 1 | Allocation request for this set |
| way_valid_i | input | NWAYS | Per-way valid bits |
| way_ts_i | input | NWAYS*TS_W | Per-way timestamps, way i in bits [i*TS_W +: TS_W] |
| timer_i | input | TS_W | Global timer |
| touch_en_i | input | 1 | Hit access: promote a way to most recent |
| touch_way_i | input | WAY_W | Way that was hit |
| victim_way_o | output | WAY_W | Chosen way; meaningful when grant_o is 1 |
| grant_o | output | 1 | Request granted, victim_way_o may be filled |
| stall_o | output | 1 | Request must wait; every way is leased |

## Verification
The assertions assume that the timer does not wrap while a lease is outstanding, because the guard compares timestamps without a modulo. They also assume that a requester treats a grant as a fill, since the recency check after a grant expects the victim to become the newest way. The bench keeps all timestamps and the timer well inside the range, and it drops the request before each clock edge during its sweeps. As a result, recency only changes through the deliberate touches and fills that the model tracks.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

    localparam int unsigned DEF_WAYS = 4;
    localparam int unsigned DEF_TS_W = 16;

    // outcome of one evaluation of the selector
    typedef enum logic [1:0] {
        PICK_IDLE  = 2'd0,
        PICK_FREE  = 2'd1,
        PICK_AGED  = 2'd2,
        PICK_STALL = 2'd3
    } pick_kind_e;

    function automatic logic pick_grants(input pick_kind_e k);
        return (k == PICK_FREE) || (k == PICK_AGED);
    endfunction

endpackage

// File: rtl/lvs_age_matrix.sv
module lvs_age_matrix #(
    parameter int unsigned NWAYS = lvs_pkg::DEF_WAYS,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     touch_en,
    input  logic [WAY_W-1:0]         touch_way,
    input  logic                     fill_en,
    input  logic [WAY_W-1:0]         fill_way,
    output logic [NWAYS*NWAYS-1:0]   newer_o    // bit i*NWAYS+j: way i newer than way j
);

    logic [NWAYS-1:0] age_q [NWAYS];
    logic [NWAYS-1:0] age_d [NWAYS];

    always_comb begin
        for (int i = 0; i < NWAYS; i++) age_d[i] = age_q[i];
        if (touch_en) begin
            for (int j = 0; j < NWAYS; j++) begin
                if (touch_way != WAY_W'(j)) begin
                    age_d[touch_way][j] = 1'b1;
                    age_d[j][touch_way] = 1'b0;
                end
            end
        end
        if (fill_en) begin
            for (int j = 0; j < NWAYS; j++) begin
                if (fill_way != WAY_W'(j)) begin
                    age_d[fill_way][j] = 1'b1;
                    age_d[j][fill_way] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWAYS; i++)
                for (int j = 0; j < NWAYS; j++)
                    age_q[i][j] <= (i > j);
        end else begin
            for (int i = 0; i < NWAYS; i++) age_q[i] <= age_d[i];
        end
    end

    generate
        for (genvar gi = 0; gi < NWAYS; gi++) begin : g_row
            assign newer_o[gi*NWAYS +: NWAYS] = age_q[gi];
        end
    endgenerate

endmodule

// File: rtl/lvs_expiry_guard.sv
module lvs_expiry_guard #(
    parameter int unsigned NWAYS = lvs_pkg::DEF_WAYS,
    parameter int unsigned TS_W  = lvs_pkg::DEF_TS_W
) (
    input  logic [NWAYS-1:0]      valid_i,
    input  logic [NWAYS*TS_W-1:0] ts_i,
    input  logic [TS_W-1:0]       timer_i,
    output logic [NWAYS-1:0]      free_o,
    output logic [NWAYS-1:0]      evict_o
);

    generate
        for (genvar gw = 0; gw < NWAYS; gw++) begin : g_way
            assign free_o[gw]  = ~valid_i[gw];
            assign evict_o[gw] = valid_i[gw] && (ts_i[gw*TS_W +: TS_W] <= timer_i);
        end
    endgenerate

endmodule

// File: rtl/lvs_pick.sv
module lvs_pick
    import lvs_pkg::*;
#(
    parameter int unsigned NWAYS = lvs_pkg::DEF_WAYS,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                   req_i,
    input  logic [NWAYS-1:0]       free_i,
    input  logic [NWAYS-1:0]       evict_i,
    input  logic [NWAYS*NWAYS-1:0] newer_i,
    output logic [WAY_W-1:0]       way_o,
    output pick_kind_e             kind_o
);

    logic [NWAYS-1:0] oldest;
    logic [WAY_W-1:0] free_idx;
    logic [WAY_W-1:0] old_idx;

    // a way is oldest when every other evictable way is newer than it
    always_comb begin
        for (int i = 0; i < NWAYS; i++) begin
            oldest[i] = evict_i[i];
            for (int j = 0; j < NWAYS; j++) begin
                if (!((j == i) || !evict_i[j] || newer_i[j*NWAYS + i]))
                    oldest[i] = 1'b0;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        old_idx  = '0;
        for (int i = NWAYS-1; i >= 0; i--) begin
            if (free_i[i]) free_idx = WAY_W'(i);
            if (oldest[i]) old_idx  = WAY_W'(i);
        end
    end

    always_comb begin
        kind_o = PICK_IDLE;
        way_o  = '0;
        if (req_i) begin
            if (|free_i) begin
                kind_o = PICK_FREE;
                way_o  = free_idx;
            end else if (|evict_i) begin
                kind_o = PICK_AGED;
                way_o  = old_idx;
            end else begin
                kind_o = PICK_STALL;
            end
        end
    end

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
    import lvs_pkg::*;
#(
    parameter int unsigned NWAYS = lvs_pkg::DEF_WAYS,
    parameter int unsigned TS_W  = lvs_pkg::DEF_TS_W,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_req_i,
    input  logic [NWAYS-1:0]      way_valid_i,
    input  logic [NWAYS*TS_W-1:0] way_ts_i,
    input  logic [TS_W-1:0]       timer_i,
    input  logic                  touch_en_i,
    input  logic [WAY_W-1:0]      touch_way_i,
    output logic [WAY_W-1:0]      victim_way_o,
    output logic                  grant_o,
    output logic                  stall_o
);

    logic [NWAYS-1:0]       free_w;
    logic [NWAYS-1:0]       evict_w;
    logic [NWAYS*NWAYS-1:0] age_flat;
    pick_kind_e             kind_w;
    logic [WAY_W-1:0]       pick_way;

    lvs_expiry_guard #(.NWAYS(NWAYS), .TS_W(TS_W)) u_guard (
        .valid_i (way_valid_i),
        .ts_i    (way_ts_i),
        .timer_i (timer_i),
        .free_o  (free_w),
        .evict_o (evict_w)
    );

    lvs_age_matrix #(.NWAYS(NWAYS)) u_age (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en_i),
        .touch_way (touch_way_i),
        .fill_en   (grant_o),
        .fill_way  (pick_way),
        .newer_o   (age_flat)
    );

    lvs_pick #(.NWAYS(NWAYS)) u_pick (
        .req_i   (alloc_req_i),
        .free_i  (free_w),
        .evict_i (evict_w),
        .newer_i (age_flat),
        .way_o   (pick_way),
        .kind_o  (kind_w)
    );

    assign victim_way_o = pick_way;
    assign grant_o      = pick_grants(kind_w);
    assign stall_o      = (kind_w == PICK_STALL);

endmodule

// File: rtl/lru_victim_sel_chk.sv
module lru_victim_sel_chk #(
    parameter int unsigned NWAYS = 4,
    parameter int unsigned TS_W  = 16,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   alloc_req_i,
    input logic [NWAYS-1:0]       way_valid_i,
    input logic [NWAYS*TS_W-1:0]  way_ts_i,
    input logic [TS_W-1:0]        timer_i,
    input logic                   touch_en_i,
    input logic [WAY_W-1:0]       touch_way_i,
    input logic [WAY_W-1:0]       victim_way_o,
    input logic                   grant_o,
    input logic                   stall_o,
    input logic [NWAYS*NWAYS-1:0] age_flat
);

    function automatic logic is_newest(input logic [NWAYS*NWAYS-1:0] m,
                                       input logic [WAY_W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < NWAYS; j++)
            if (WAY_W'(j) != w && !m[int'(w)*NWAYS + j]) ok = 1'b0;
        return ok;
    endfunction

    // R1: a granted valid way has an expired timestamp
    assert_guard_R1: assert property (@(posedge clk) disable iff (rst)
        (grant_o && way_valid_i[victim_way_o]) |->
            (way_ts_i[victim_way_o*TS_W +: TS_W] <= timer_i));

    // R2: stall only with a request and a full set, never together with grant
    assert_stall_R2: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (alloc_req_i && !grant_o && (&way_valid_i)));

    // R4: a free way is always taken before any valid way
    assert_free_R4: assert property (@(posedge clk) disable iff (rst)
        (grant_o && !(&way_valid_i)) |-> !way_valid_i[victim_way_o]);

    // R8: the filled way is the newest after the edge
    assert_fill_mru_R8: assert property (@(posedge clk) disable iff (rst)
        grant_o |=> is_newest(age_flat, $past(victim_way_o)));

    // R7: a touched way is the newest after the edge when no fill follows it
    assert_touch_mru_R7: assert property (@(posedge clk) disable iff (rst)
        (touch_en_i && !grant_o) |=> is_newest(age_flat, $past(touch_way_i)));

    // R10: no request, no answer
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !alloc_req_i |-> (!grant_o && !stall_o));

endmodule

bind lru_victim_sel lru_victim_sel_chk #(.NWAYS(NWAYS), .TS_W(TS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .alloc_req_i  (alloc_req_i),
    .way_valid_i  (way_valid_i),
    .way_ts_i     (way_ts_i),
    .timer_i      (timer_i),
    .touch_en_i   (touch_en_i),
    .touch_way_i  (touch_way_i),
    .victim_way_o (victim_way_o),
    .grant_o      (grant_o),
    .stall_o      (stall_o),
    .age_flat     (age_flat)
);

// File: tb/lru_victim_sel_bench.sv
module lru_victim_sel_bench;

    localparam int NW    = 4;
    localparam int TW    = 16;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          alloc_req = 1'b0;
    logic [NW-1:0] valid = '0;
    logic [NW*TW-1:0] ts = '0;
    logic [TW-1:0] timer = '0;
    logic          touch_en = 1'b0;
    logic [1:0]    touch_way = '0;
    logic [1:0]    victim;
    logic          grant;
    logic          stall;

    int n_chk = 0;
    int n_bad = 0;
    int ord [NW];   // ord[0] least recent
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    lru_victim_sel #(.NWAYS(NW), .TS_W(TW)) u_lru_victim_sel (
        .clk(clk), .rst(rst), .alloc_req_i(alloc_req), .way_valid_i(valid),
        .way_ts_i(ts), .timer_i(timer), .touch_en_i(touch_en),
        .touch_way_i(touch_way), .victim_way_o(victim), .grant_o(grant),
        .stall_o(stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_promote(input int w);
        int p;
        p = 0;
        for (int i = 0; i < NW; i++) if (ord[i] == w) p = i;
        for (int i = p; i < NW-1; i++) ord[i] = ord[i+1];
        ord[NW-1] = w;
    endtask

    // set per-way timestamps: expired pattern em, relative to current timer
    task automatic set_ts(input logic [NW-1:0] em);
        for (int i = 0; i < NW; i++)
            ts[i*TW +: TW] = em[i] ? ((i == 0) ? TW'(0) : TW'(timer - TW'(i-1)))
                                   : TW'(timer + TW'(1 + i));
    endtask

    // one combinational probe between edges; request dropped before the edge
    task automatic probe(input string req, input logic [NW-1:0] vm, input logic [NW-1:0] em);
        int ew, eg, es;
        @(negedge clk);
        valid = vm;
        set_ts(em);
        alloc_req = 1'b1;
        eg = 1; es = 0; ew = -1;
        for (int i = NW-1; i >= 0; i--) if (!vm[i]) ew = i;
        if (ew < 0) begin
            for (int i = NW-1; i >= 0; i--) if (em[ord[i]]) ew = ord[i];
            if (ew < 0) begin eg = 0; es = 1; end
        end
        #1;
        chk(req, "grant", int'(grant), eg);
        chk(req, "stall", int'(stall), es);
        if (eg == 1) chk(req, "victim", int'(victim), ew);
        #1 alloc_req = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int vm = 0; vm < 16; vm++)
            for (int em = 0; em < 16; em++)
                probe(req, 4'(vm), 4'(em));
    endtask

    task automatic do_touch(input int w);
        @(negedge clk);
        touch_en = 1'b1; touch_way = 2'(w);
        @(negedge clk);
        touch_en = 1'b0;
        model_promote(w);
    endtask

    initial begin
        for (int i = 0; i < NW; i++) ord[i] = i;
        timer = 16'd1000;
        repeat (3) @(negedge clk);
        #1;
        chk("R10", "grant in reset", int'(grant), 0);
        chk("R10", "stall in reset", int'(stall), 0);
        rst = 1'b0;

        // R9: reset order, way 0 oldest; R10 idle
        @(negedge clk);
        valid = '1; set_ts('1); #1;
        chk("R10", "grant idle", int'(grant), 0);
        chk("R10", "stall idle", int'(stall), 0);
        probe("R9", 4'hF, 4'hF);
        probe("R9", 4'hF, 4'hE);

        // full sweep in reset order: R1 R2 R3 R4 R5
        sweep("R1/R2/R3/R4/R5");

        // R7: touches reorder recency
        do_touch(0);
        do_touch(2);
        probe("R7", 4'hF, 4'hF);
        probe("R7", 4'hF, 4'h5);
        sweep("R5/R7");

        // R8: a grant with all ways valid and expired fills the oldest
        @(negedge clk);
        valid = '1; set_ts('1); alloc_req = 1'b1; #1;
        chk("R8", "fill victim", int'(victim), ord[0]);
        model_promote(ord[0]);
        @(negedge clk);
        alloc_req = 1'b0;
        probe("R8", 4'hF, 4'hF);

        // R8: touch and fill on the same edge; fill ends newest
        @(negedge clk);
        begin
            int fw, tw;
            fw = ord[0]; tw = ord[1];
            valid = '1; set_ts('1); alloc_req = 1'b1;
            touch_en = 1'b1; touch_way = 2'(tw);
            #1;
            chk("R8", "fill victim with touch", int'(victim), fw);
            model_promote(tw);
            model_promote(fw);
        end
        @(negedge clk);
        alloc_req = 1'b0; touch_en = 1'b0;
        probe("R8", 4'hF, 4'hF);
        sweep("R5/R8");

        // R6: stall drops the cycle the timer reaches the smallest lease
        @(negedge clk);
        valid = '1;
        ts = {16'd800, 16'd700, 16'd500, 16'd600};
        timer = 16'd498;
        alloc_req = 1'b1;
        #1;
        chk("R6", "stall at 498", int'(stall), 1);
        chk("R2", "grant at 498", int'(grant), 0);
        @(negedge clk);
        timer = 16'd499; alloc_req = 1'b0;
        #1;
        chk("R6", "stall at 499 no req", int'(stall), 0);
        alloc_req = 1'b1;
        #1;
        chk("R6", "stall at 499", int'(stall), 1);
        #1 alloc_req = 1'b0;
        @(negedge clk);
        timer = 16'd500; alloc_req = 1'b1;
        #1;
        chk("R6", "stall at 500", int'(stall), 0);
        chk("R6", "grant at 500", int'(grant), 1);
        chk("R3", "equal timestamp way", int'(victim), 1);
        #1 alloc_req = 1'b0;

        // R3: timestamp zero on a full set with a large timer gap
        @(negedge clk);
        timer = 16'd10;
        ts = {16'd900, 16'd0, 16'd900, 16'd900};
        alloc_req = 1'b1;
        #1;
        chk("R3", "null timestamp victim", int'(victim), 2);
        chk("R1", "leased ways skipped", int'(grant), 1);
        #1 alloc_req = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule